// File: doc/BRIEF.md
# Cascaded Synchronous Up-Counter

This block is a 12-bit binary up-counter made of three identical 4-bit counter slices that share one clock. Every slice has a synchronous clear, a synchronous parallel load, two count enables and a carry output. A slice counts only when both of its enables are high. Its carry output is high when the slice holds all ones and its second enable is high. The slices form a chain, lowest nibble first. A single master enable drives the first enable of every slice. The carry chain runs through the second enable of each upper slice, so a slice advances only when every slice below it is at its maximum.

The surrounding logic uses the block as an event or cycle counter. It can preset the count, zero it, or freeze it. The final carry output marks the cycle in which the next enabled edge wraps the full count back to zero, and a wider counter can take it as its own enable. An asynchronous active-low reset puts the count at zero.

Top module: `cascCounter`

## Requirements
- R1: The count changes only on the rising edge of `clk`. While `rstN` is low the count is 0, and it stays 0 until the first enabled edge.
- R2: When `clearN` is low at a rising edge, the count becomes 0. This overrides `loadN` and `enable`.
- R3: When `clearN` is high and `loadN` is low at a rising edge, the count takes `loadValue`, whatever `enable` is. Bits 3:0, 7:4 and 11:8 of `loadValue` go to the lowest, middle and top slice.
- R4: When `clearN` and `loadN` are high and `enable` is high, the count goes up by one at each edge, modulo 4096.
- R5: When `clearN` and `loadN` are high and `enable` is low, the count holds its value and `carryOut` is low.
- R6: `carryOut` is high exactly when the count is 12'hFFF and `enable` is high.
- R7: The middle nibble advances once per 16 enabled cycles and the top nibble once per 256. An upper nibble changes by counting only after the edge at which all lower bits were ones. A middle nibble at all ones does not make the top nibble count more than once.
- R8: From 12'hFFF, an enabled edge with no clear or load wraps the count to 12'h000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Master count enable |
| clearN | input | 1 | Synchronous clear, active low |
| loadN | input | 1 | Synchronous parallel load, active low |
| loadValue | input | 12 | Value taken on a load |
| count | output | 12 | Current count |
| carryOut | output | 1 | Terminal carry, high at 12'hFFF with enable high |

## Verification
The bench starts from 12'h3F0 and runs 256 enabled cycles. It counts how often the middle and top nibbles change. A chain that fed the carry into the first enable would advance the top nibble sixteen times in that window instead of once. It checks the carry output before an edge at 12'hFFF with the enable both high and low, and it checks that the following edge wraps to zero. A carry that ignored the enable, or a wrap that carried into phantom bits, would show there. Long random mixes of clear, load and enable are compared against a plain 12-bit model. They expose a wrong priority between clear and load, or a load that is blocked while the enable is low.

// File: rtl/cascCntPkg.sv
package cascCntPkg;
  typedef struct packed {
    logic clr;
    logic ld;
    logic cnt;
  } ctrlStrobes_t;
endpackage

// File: rtl/chainCtrl.sv
module chainCtrl
  import cascCntPkg::*;
(
  input  logic         enable,
  input  logic         clearN,
  input  logic         loadN,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.clr = ~clearN;
    strobes.ld  = clearN & ~loadN;
    strobes.cnt = enable;
  end
endmodule

// File: rtl/countSlice.sv
module countSlice #(
  parameter int SLICE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clr,
  input  logic               ld,
  input  logic               pEn,
  input  logic               tEn,
  input  logic [SLICE_W-1:0] dIn,
  output logic [SLICE_W-1:0] q,
  output logic               rco
);
  localparam logic [SLICE_W-1:0] ONE = SLICE_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            q <= '0;
    else if (clr)         q <= '0;
    else if (ld)          q <= dIn;
    else if (pEn && tEn)  q <= q + ONE;
  end

  assign rco = (&q) & tEn;

  AST_SLICE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (q == '0)); // R2
  AST_SLICE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && ld) |=> (q == $past(dIn))); // R3
  AST_SLICE_INC: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && !ld && pEn && tEn) |=> (q == $past(q) + ONE)); // R4
  AST_SLICE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && !ld && !(pEn && tEn)) |=> $stable(q)); // R5
endmodule

// File: rtl/countPath.sv
module countPath
  import cascCntPkg::*;
#(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobes_t                  strobes,
  input  logic [SLICE_W*NUM_SLICES-1:0] loadValue,
  output logic [SLICE_W*NUM_SLICES-1:0] count,
  output logic                          carryOut
);
  logic [NUM_SLICES:0]   tChain;
  logic [NUM_SLICES-1:0] rcoVec;

  assign tChain[0] = strobes.cnt;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    countSlice #(.SLICE_W(SLICE_W)) u_slice (
      .clk  (clk),
      .rstN (rstN),
      .clr  (strobes.clr),
      .ld   (strobes.ld),
      .pEn  (strobes.cnt),
      .tEn  (tChain[i]),
      .dIn  (loadValue[i*SLICE_W +: SLICE_W]),
      .q    (count[i*SLICE_W +: SLICE_W]),
      .rco  (rcoVec[i])
    );
    assign tChain[i+1] = rcoVec[i];
  end

  assign carryOut = tChain[NUM_SLICES];

  for (genvar j = 1; j < NUM_SLICES; j++) begin : g_chainChk
    logic lowerMax;
    assign lowerMax = &count[j*SLICE_W-1:0];
    AST_UPPER_STEP: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes.clr && !strobes.ld) |=>
        ($stable(count[j*SLICE_W +: SLICE_W]) || ($past(lowerMax) && $past(strobes.cnt)))); // R7
  end
endmodule

// File: rtl/cascCounter.sv
module cascCounter
  import cascCntPkg::*;
#(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 3,
  localparam int TOTAL_W   = SLICE_W * NUM_SLICES
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               clearN,
  input  logic               loadN,
  input  logic [TOTAL_W-1:0] loadValue,
  output logic [TOTAL_W-1:0] count,
  output logic               carryOut
);
  ctrlStrobes_t strobes;

  chainCtrl u_ctrl (
    .enable  (enable),
    .clearN  (clearN),
    .loadN   (loadN),
    .strobes (strobes)
  );

  countPath #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .loadValue (loadValue),
    .count     (count),
    .carryOut  (carryOut)
  );

  AST_IDLE_NO_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !carryOut); // R5
  AST_CARRY_AT_MAX: assert property (@(posedge clk) disable iff (!rstN)
    carryOut |-> ((&count) && enable)); // R6
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((&count) && enable && clearN && loadN) |=> (count == '0)); // R8
endmodule

// File: tb/cascCounter_bench.sv
`timescale 1ns/1ps
module cascCounter_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        enable, clearN, loadN;
  logic [11:0] loadValue;
  logic [11:0] count;
  logic        carryOut;
  logic [11:0] model;
  int          nChecks = 0;
  int          nFails  = 0;
  bit          doneFlag = 0;

  always #2.5 clk = ~clk;

  cascCounter u_cascCounter (
    .clk(clk), .rstN(rstN), .enable(enable), .clearN(clearN),
    .loadN(loadN), .loadValue(loadValue), .count(count), .carryOut(carryOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, check carry before edge, check count after edge
  task automatic step(input logic en, input logic clrN, input logic ldN,
                      input logic [11:0] val, input string req);
    @(negedge clk);
    enable = en; clearN = clrN; loadN = ldN; loadValue = val;
    #1;
    check({req, "/R6 carry"}, carryOut, (model == 12'hFFF) && en);
    @(posedge clk);
    if (!clrN)     model = 12'h000;
    else if (!ldN) model = val;
    else if (en)   model = model + 12'h001;
    #1;
    check({req, " count"}, count, model);
  endtask

  task automatic testReset();
    rstN = 1'b0; enable = 1'b1; clearN = 1'b1; loadN = 1'b1; loadValue = 12'h5A5;
    model = 12'h000;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset count", count, 12'h000);
    @(negedge clk);
    enable = 1'b0;
    rstN = 1'b1;
    #1;
    check("R1 reset carry", carryOut, 1'b0);
    step(1'b0, 1'b1, 1'b1, 12'h000, "R1 idle after reset");
  endtask

  task automatic testLoad();
    step(1'b0, 1'b1, 1'b0, 12'hABC, "R3 load enable low");
    step(1'b1, 1'b1, 1'b0, 12'h123, "R3 load enable high");
  endtask

  task automatic testClear();
    step(1'b1, 1'b0, 1'b0, 12'h777, "R2 clear beats load");
    step(1'b1, 1'b1, 1'b0, 12'h456, "R3 reload");
    step(1'b0, 1'b0, 1'b1, 12'h000, "R2 clear enable low");
  endtask

  task automatic testCount();
    step(1'b1, 1'b1, 1'b0, 12'h0F8, "R3 preset");
    for (int k = 0; k < 40; k++) step(1'b1, 1'b1, 1'b1, 12'h000, "R4 increment");
  endtask

  task automatic testHold();
    logic [11:0] held;
    step(1'b1, 1'b1, 1'b0, 12'h2FF, "R3 preset");
    held = count;
    for (int k = 0; k < 10; k++) step(1'b0, 1'b1, 1'b1, 12'h000, "R5 hold");
    check("R5 value unchanged", count, held);
  endtask

  task automatic testWrap();
    step(1'b1, 1'b1, 1'b0, 12'hFFF, "R3 preset max");
    step(1'b0, 1'b1, 1'b1, 12'h000, "R5 max idle no carry");
    step(1'b1, 1'b1, 1'b1, 12'h000, "R8 wrap");
    check("R8 wrapped to zero", count, 12'h000);
    check("R6 carry low after wrap", carryOut, 1'b0);
  endtask

  task automatic testCascade();
    int midSteps = 0;
    int topSteps = 0;
    logic [3:0] prevMid, prevTop;
    step(1'b1, 1'b1, 1'b0, 12'h3F0, "R3 preset cascade");
    for (int k = 0; k < 256; k++) begin
      prevMid = count[7:4];
      prevTop = count[11:8];
      step(1'b1, 1'b1, 1'b1, 12'h000, "R7 cascade");
      if (count[7:4]  != prevMid) midSteps++;
      if (count[11:8] != prevTop) topSteps++;
    end
    check("R7 middle steps in 256", midSteps, 16);
    check("R7 top steps in 256", topSteps, 1);
    check("R7 top nibble", count[11:8], 4'h4);
  endtask

  task automatic testRandom();
    for (int k = 0; k < 3000; k++) begin
      logic en, c, l;
      en = ($urandom_range(0, 9) < 7);
      c  = ($urandom_range(0, 99) >= 2);
      l  = ($urandom_range(0, 99) >= 3);
      step(en, c, l, 12'($urandom), "R4 random vs model");
    end
  endtask

  initial begin
    testReset();
    testLoad();
    testClear();
    testCount();
    testHold();
    testWrap();
    testCascade();
    testRandom();
    doneFlag = 1;
  end

  initial begin
    fork
      wait (doneFlag);
      begin
        repeat (100000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule